// File: doc/BRIEF.md
# Auto-Increment Byte Write Port

This block lets a slow processor fill an on-chip RAM one byte at a time without ever driving an address. The processor puts a byte on the data pins and pulses an active-high write strobe. The block runs on a much faster system clock. It passes the strobe and the data through a two-flop synchronizer and treats each synchronized edge of the strobe as an event. On the leading edge it latches the byte. On the trailing edge it issues exactly one RAM write and steps an internal address pointer.

A mode input chooses the addressing order. In post-increment mode the byte goes to the current pointer and the pointer then steps. In pre-increment mode the pointer steps first and the byte goes to the new location. In both modes the pointer wraps after the top location, and at the wrap a full flag sets. While the flag is set, strobes are ignored. A synchronous clear input returns the pointer to zero, drops the flag, and discards any byte that has been latched but not yet written.

Top module: `seq_wr_port`

## Requirements
- R1: After reset, `ptr_o` is 0, `full_o` is 0 and `ram_we_o` is 0.
- R2: The byte written is the value on `data_i` when the synchronized leading edge of `stb_i` is detected. Changes to `data_i` made one or more clocks after that edge, while the strobe is still high, do not change the written byte.
- R3: Each high pulse of `stb_i` produces exactly one one-cycle `ram_we_o` pulse, whatever the pulse length. `ram_we_o` is high in the cycle after the third rising clock edge that follows the strobe's deassertion.
- R4: With `pre_inc_i` = 0, a write goes to address `ptr_o`, and `ptr_o` shows that address plus 1 (modulo 2^ADDR_W) in the same cycle that `ram_we_o` is high. `ptr_o` changes only on a write or a clear.
- R5: With `pre_inc_i` = 1, a write goes to `ptr_o` + 1 (modulo 2^ADDR_W), and `ptr_o` shows that same address while `ram_we_o` is high. After a clear, the first write therefore goes to address 1.
- R6: The write that moves the pointer from 2^ADDR_W-1 back to 0 sets `full_o` in the same cycle. That write uses address 2^ADDR_W-1 in post-increment mode and address 0 in pre-increment mode.
- R7: While `full_o` is 1, strobe pulses produce no write, and `ptr_o` stays unchanged.
- R8: `clr_i` high at a rising edge gives `ptr_o` = 0, `full_o` = 0 and no write in the next cycle. It has priority over strobe events. A byte that was latched before the clear and not yet written is dropped, so its trailing edge produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of pointer, full flag and pending byte |
| pre_inc_i | input | 1 | 1 selects pre-increment, 0 selects post-increment |
| stb_i | input | 1 | Asynchronous write strobe from the processor, active high |
| data_i | input | DATA_W | Byte from the processor, asynchronous |
| ram_we_o | output | 1 | RAM write enable, one cycle per write |
| ram_addr_o | output | ADDR_W | RAM write address, valid while `ram_we_o` is high |
| ram_data_o | output | DATA_W | RAM write data, valid while `ram_we_o` is high |
| ptr_o | output | ADDR_W | Current address pointer |
| full_o | output | 1 | Set when the pointer has wrapped |

## Verification
The properties assume that `pre_inc_i` changes only in a cycle where `clr_i` is high, and that `clr_i` is synchronous to the system clock. They also assume that the processor holds `data_i` steady from two clocks before the strobe rises until at least one clock after it. The stimulus keeps to these rules. It sets each byte two clocks before raising the strobe and alters data inside a pulse only after four clocks. It switches the mode only together with a clear. It always drives pins just after a falling clock edge, so the synchronizer never sees a change at the sampling edge.

// File: rtl/seq_wr_pkg.sv
package seq_wr_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_HELD = 1'b1
  } wr_state_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } strobe_evt_t;
endpackage

// File: rtl/seq_wr_sync.sv
module seq_wr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= '0;
        else         stage_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= '0;
        else         stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/seq_wr_edge.sv
module seq_wr_edge (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lvl_i,
  output seq_wr_pkg::strobe_evt_t  evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign evt_o.rise = lvl_i & ~prev_q;
  assign evt_o.fall = ~lvl_i & prev_q;
endmodule

// File: rtl/seq_wr_ptr.sv
module seq_wr_ptr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              full_o
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic [ADDR_W-1:0] ptr_q;
  logic              full_q;

  assign nxt_o = ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
    end else if (clr_i) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
    end else if (step_i) begin
      ptr_q <= nxt_o;
      if (ptr_q == LAST) full_q <= 1'b1;
    end
  end

  assign ptr_o  = ptr_q;
  assign full_o = full_q;
endmodule

// File: rtl/seq_wr_ctrl.sv
module seq_wr_ctrl #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     pre_inc_i,
  input  seq_wr_pkg::strobe_evt_t  evt_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     full_i,
  input  logic [ADDR_W-1:0]        ptr_i,
  input  logic [ADDR_W-1:0]        nxt_i,
  output logic                     step_o,
  output logic                     ram_we_o,
  output logic [ADDR_W-1:0]        ram_addr_o,
  output logic [DATA_W-1:0]        ram_data_o
);
  import seq_wr_pkg::*;

  wr_state_e         state_q;
  logic [DATA_W-1:0] lat_q;
  logic              take;
  logic              issue;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;

  // clear wins over both events; a full pointer refuses new bytes
  assign take  = evt_i.rise && !full_i && !clr_i;
  assign issue = evt_i.fall && (state_q == ST_HELD) && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lat_q   <= '0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
    end else if (take) begin
      state_q <= ST_HELD;
      lat_q   <= data_i;
    end else if (issue) begin
      state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      we_q <= issue;
      if (issue) begin
        addr_q <= pre_inc_i ? nxt_i : ptr_i;
        wdat_q <= lat_q;
      end
    end
  end

  assign step_o     = issue;
  assign ram_we_o   = we_q;
  assign ram_addr_o = addr_q;
  assign ram_data_o = wdat_q;
endmodule

// File: rtl/seq_wr_port.sv
module seq_wr_port #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              pre_inc_i,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_data_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              full_o
);
  localparam int SYNC_W = DATA_W + 1;

  logic [SYNC_W-1:0]        sync_d;
  logic [SYNC_W-1:0]        sync_q;
  seq_wr_pkg::strobe_evt_t  evt;
  logic                     step;
  logic [ADDR_W-1:0]        ptr;
  logic [ADDR_W-1:0]        nxt;
  logic                     full;

  assign sync_d = {stb_i, data_i};

  seq_wr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sync_d),
    .q_o    (sync_q)
  );

  seq_wr_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sync_q[SYNC_W-1]),
    .evt_o  (evt)
  );

  seq_wr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .step_i (step),
    .ptr_o  (ptr),
    .nxt_o  (nxt),
    .full_o (full)
  );

  seq_wr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .pre_inc_i  (pre_inc_i),
    .evt_i      (evt),
    .data_i     (sync_q[DATA_W-1:0]),
    .full_i     (full),
    .ptr_i      (ptr),
    .nxt_i      (nxt),
    .step_o     (step),
    .ram_we_o   (ram_we_o),
    .ram_addr_o (ram_addr_o),
    .ram_data_o (ram_data_o)
  );

  assign ptr_o  = ptr;
  assign full_o = full;
endmodule

// File: rtl/seq_wr_port_chk.sv
module seq_wr_port_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic              pre_inc_i,
  input logic              ram_we_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic [ADDR_W-1:0] ptr_o,
  input logic              full_o
);
  p_one_cycle_we_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !ram_we_o);

  p_post_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && !pre_inc_i) |-> (ptr_o == ADDR_W'(ram_addr_o + 1'b1)));

  p_ptr_only_on_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_o |-> ($stable(ptr_o) || $past(clr_i)));

  p_pre_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && pre_inc_i) |-> (ptr_o == ram_addr_o));

  p_wrap_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> (ram_we_o && ptr_o == '0));

  p_no_write_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> !ram_we_o);

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ptr_o == '0 && !full_o && !ram_we_o));
endmodule

bind seq_wr_port seq_wr_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .pre_inc_i  (pre_inc_i),
  .ram_we_o   (ram_we_o),
  .ram_addr_o (ram_addr_o),
  .ptr_o      (ptr_o),
  .full_o     (full_o)
);

// File: tb/sim_seq_wr_port.sv
`timescale 1ns/1ps
module sim_seq_wr_port;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, pre = 1'b0, stb = 1'b0;
  logic [DATA_W-1:0] dat = '0;
  logic              we, full;
  logic [ADDR_W-1:0] addr, ptr;
  logic [DATA_W-1:0] wdat;

  int    checks = 0, errors = 0, writes = 0;
  int    last_addr = -1, last_data = -1;
  bit    done = 1'b0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  seq_wr_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .pre_inc_i(pre), .stb_i(stb),
    .data_i(dat), .ram_we_o(we), .ram_addr_o(addr), .ram_data_o(wdat),
    .ptr_o(ptr), .full_o(full));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: strobe/data seen two edges late, events by level history
  int  h1, h2, h3, dh1, dh2;
  int  m_ptr, m_addr, m_data, m_lat;
  bit  m_we, m_full, m_held;
  int  lvl, old;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; dh1 = 0; dh2 = 0;
      m_ptr = 0; m_addr = 0; m_data = 0; m_lat = 0;
      m_we = 0; m_full = 0; m_held = 0;
    end else begin
      lvl = h2; old = h3;
      m_we = 0;
      if (clr) begin
        m_ptr = 0; m_full = 0; m_held = 0;
      end else if (lvl == 1 && old == 0 && !m_full) begin
        m_held = 1; m_lat = dh2;
      end else if (lvl == 0 && old == 1 && m_held) begin
        m_we   = 1;
        m_addr = pre ? (m_ptr + 1) % DEPTH : m_ptr;
        m_data = m_lat;
        if (m_ptr == DEPTH - 1) m_full = 1;
        m_ptr  = (m_ptr + 1) % DEPTH;
        m_held = 0;
      end
      h3 = h2; h2 = h1; h1 = int'(stb);
      dh2 = dh1; dh1 = int'(dat);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, "ram_we_o", int'(we), int'(m_we));
      chk(phase, "ptr_o", int'(ptr), m_ptr);
      chk(phase, "full_o", int'(full), int'(m_full));
      if (m_we) begin
        chk(phase, "ram_addr_o", int'(addr), m_addr);
        chk(phase, "ram_data_o", int'(wdat), m_data);
      end
      if (we) begin
        writes++;
        last_addr = int'(addr);
        last_data = int'(wdat);
      end
    end
  end

  task automatic pulse(input logic [DATA_W-1:0] v, input int hi, input int lo = 5,
                       input int chg_at = -1, input logic [DATA_W-1:0] v2 = '0);
    @(negedge clk); dat = v;
    repeat (2) @(negedge clk);
    stb = 1'b1;
    for (int i = 0; i < hi; i++) begin
      @(negedge clk);
      if (i == chg_at) dat = v2;
    end
    stb = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic clear(input logic mode);
    @(negedge clk); clr = 1'b1; pre = mode;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ptr_o after reset", int'(ptr), 0);
    chk("R1", "full_o after reset", int'(full), 0);
    chk("R1", "ram_we_o after reset", int'(we), 0);

    phase = "R4";
    pulse(8'h11, 1);
    chk("R4", "first post-inc address", last_addr, 0);
    pulse(8'h22, 3, 3);
    pulse(8'h33, 7, 4);
    chk("R4", "pointer after three writes", int'(ptr), 3);

    phase = "R3";
    w0 = writes;
    pulse(8'h44, 60, 6);
    chk("R3", "writes from one long pulse", writes - w0, 1);

    phase = "R2";
    pulse(8'h5A, 8, 5, 3, 8'hA5);
    chk("R2", "byte latched at leading edge", last_data, 32'h5A);

    phase = "R6";
    for (int i = 5; i < DEPTH; i++) pulse(DATA_W'(i * 7 + 1), 2 + (i % 4));
    chk("R6", "full_o after wrap", int'(full), 1);
    chk("R6", "pointer after wrap", int'(ptr), 0);
    chk("R6", "last post-inc address", last_addr, DEPTH - 1);

    phase = "R7";
    w0 = writes;
    pulse(8'hE1, 3);
    pulse(8'hE2, 20);
    chk("R7", "writes while full", writes - w0, 0);
    chk("R7", "pointer while full", int'(ptr), 0);

    phase = "R8";
    clear(1'b0);
    chk("R8", "full_o after clear", int'(full), 0);
    chk("R8", "pointer after clear", int'(ptr), 0);
    w0 = writes;
    @(negedge clk); dat = 8'h77;
    repeat (2) @(negedge clk);
    stb = 1'b1;
    repeat (6) @(negedge clk);
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    repeat (3) @(negedge clk);
    stb = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8", "writes from pulse cut by clear", writes - w0, 0);
    pulse(8'h78, 4);
    chk("R8", "address after clear", last_addr, 0);

    phase = "R5";
    clear(1'b1);
    pulse(8'h90, 2);
    chk("R5", "first pre-inc address", last_addr, 1);
    chk("R5", "pointer after first pre-inc write", int'(ptr), 1);
    for (int i = 1; i < DEPTH; i++) pulse(DATA_W'(8'h90 + i), 1 + (i % 5));
    chk("R6", "last pre-inc address", last_addr, 0);
    chk("R6", "full_o after pre-inc wrap", int'(full), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule